// File: doc/BRIEF.md
# Interval Timer with Reload Latch and Interrupt Flags

This block is a byte-addressed peripheral timer. It holds two 16-bit down-counters, a 16-bit reload latch for the first counter, a mode register, an interrupt flag register, an interrupt enable register and one interrupt request line. Software reaches every register over a simple strobe bus: a 4-bit offset, write data, a write strobe, a read strobe and combinational read data. The counters move only on cycles where the `tick` input is high. This lets the block run from any divided time base.

Timer 1 can run in a continuous mode. In that mode it raises its flag once the loaded count has expired. After that it raises the flag once per latch period, reloading from the latch each time. Timer 2 is a plain down-counter that wraps and never interrupts. A shift-register byte register is also included. Its interrupt flag is set by an external `shift_done` pulse and cleared by reading the byte.

Top module: `ivt_timer`

## Requirements
- R1: After reset, both counters read 0xFFFF, the latch reads 0x0000 (a latch value of 0 stands for a period of 65536 ticks), the mode, flags and enables are 0, and `irq` is low.
- R2: A write to offset 4 replaces the low byte of the timer 1 counter and keeps its current high byte. A write to offset 5 replaces the high byte and keeps the low byte. Either write takes effect at once, overriding a tick in the same cycle. Offsets 4 and 5 read the live low and high bytes.
- R3: Writes to offsets 6 (low) and 7 (high) set the timer 1 latch bytes without changing the running counter. Offsets 6 and 7 read the latch back.
- R4: A counter changes only on a clock edge where `tick` is high, or when it is written.
- R5: When the mode register (offset 11) has bits [7:6] = 2'b01 (continuous), the timer 1 flag (flag bit 6) is set N+1 ticks after the counter was loaded with N. After that it is set once every L ticks, where L is the latch value (0 means 65536). The counter reloads to L-1 on each expiry.
- R6: With any other value in mode bits [7:6], timer 1 never sets its flag, and its counter wraps from 0 to 0xFFFF. Writing such a mode value stops periodic flags immediately.
- R7: Offsets 8 and 9 write and read the timer 2 counter bytes under the same merge rule as R2. Timer 2 wraps from 0 to 0xFFFF and never sets any flag.
- R8: `irq` is high exactly when (timer 1 flag and enable) or (shift flag and enable) is set. Offset 13 reads {irq, T1 flag, 000, shift flag, 00}.
- R9: Writing offset 13 clears each flag whose bit (6 or 2) is written as 1. Writing offset 14 sets the enables for bits 6 and 2 that are written as 1 when data bit 7 is 1, and clears them when data bit 7 is 0. Offset 14 reads {0, T1 enable, 000, shift enable, 00}.
- R10: Offset 10 stores a byte on write and returns it on read. A `shift_done` pulse sets the shift flag (bit 2). A read of offset 10 clears that flag.
- R11: A read of offset 4 clears the timer 1 flag. In the same cycle, setting a flag wins over clearing it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears flags on read) |
| rdata | output | 8 | Read data for `addr` |
| tick | input | 1 | Count enable for both counters |
| shift_done | input | 1 | Pulse that sets the shift flag |
| irq | output | 1 | Interrupt request |

## Verification
Continuous-mode timing is tried with a table of counter loads, latch values and tick spacings. The table includes a zero counter, a one-tick latch and sparse ticks. These cases separate an off-by-one in the first expiry from one in the period, and counting ticks from counting cycles. A run from the reset state checks the 65536-tick meaning of the all-ones counter. Directed tests cover the following:
- byte merges on both timers;
- latch writes against a live counter;
- wrap without flags outside continuous mode, and disarming mid-count;
- the set and clear paths of both flags through masking, flag writes and clearing reads.

// File: rtl/ivt_timer.sv
module ivt_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  input  logic       tick,
  input  logic       shift_done,
  output logic       irq
);
  localparam logic [3:0] A_T1L = 4'd4, A_T1H = 4'd5, A_LL = 4'd6, A_LH = 4'd7;
  localparam logic [3:0] A_T2L = 4'd8, A_T2H = 4'd9, A_SR = 4'd10, A_MODE = 4'd11;
  localparam logic [3:0] A_FLG = 4'd13, A_ENA = 4'd14;
  localparam logic [1:0] MODE_CONT = 2'b01;

  logic [15:0] t1_cnt, t1_latch, t2_cnt;
  logic [7:0]  sr_q, mode_q;
  logic        t1_flag, sr_flag, t1_ena, sr_ena;

  wire wr_t1  = wr_en && (addr == A_T1L || addr == A_T1H);
  wire wr_t2  = wr_en && (addr == A_T2L || addr == A_T2H);
  wire t1_cont = (mode_q[7:6] == MODE_CONT);
  wire t1_fire = t1_cont && tick && !wr_t1 && (t1_cnt == 16'd0);
  wire clr_t1 = (wr_en && addr == A_FLG && wdata[6]) || (rd_en && addr == A_T1L);
  wire clr_sr = (wr_en && addr == A_FLG && wdata[2]) || (rd_en && addr == A_SR);

  assign irq = (t1_flag && t1_ena) || (sr_flag && sr_ena);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_cnt   <= 16'hFFFF;
      t2_cnt   <= 16'hFFFF;
      t1_latch <= 16'h0000;
      sr_q     <= 8'h00;
      mode_q   <= 8'h00;
    end else begin
      if (wr_en && addr == A_T1L)      t1_cnt <= {t1_cnt[15:8], wdata};
      else if (wr_en && addr == A_T1H) t1_cnt <= {wdata, t1_cnt[7:0]};
      else if (tick)                   t1_cnt <= t1_fire ? t1_latch - 16'd1 : t1_cnt - 16'd1;

      if (wr_en && addr == A_T2L)      t2_cnt <= {t2_cnt[15:8], wdata};
      else if (wr_en && addr == A_T2H) t2_cnt <= {wdata, t2_cnt[7:0]};
      else if (tick)                   t2_cnt <= t2_cnt - 16'd1;

      if (wr_en && addr == A_LL) t1_latch[7:0]  <= wdata;
      if (wr_en && addr == A_LH) t1_latch[15:8] <= wdata;
      if (wr_en && addr == A_SR)   sr_q   <= wdata;
      if (wr_en && addr == A_MODE) mode_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_flag <= 1'b0;
      sr_flag <= 1'b0;
      t1_ena  <= 1'b0;
      sr_ena  <= 1'b0;
    end else begin
      t1_flag <= t1_fire || (t1_flag && !clr_t1);
      sr_flag <= shift_done || (sr_flag && !clr_sr);
      if (wr_en && addr == A_ENA) begin
        if (wdata[6]) t1_ena <= wdata[7];
        if (wdata[2]) sr_ena <= wdata[7];
      end
    end
  end

  always_comb begin
    case (addr)
      A_T1L:   rdata = t1_cnt[7:0];
      A_T1H:   rdata = t1_cnt[15:8];
      A_LL:    rdata = t1_latch[7:0];
      A_LH:    rdata = t1_latch[15:8];
      A_T2L:   rdata = t2_cnt[7:0];
      A_T2H:   rdata = t2_cnt[15:8];
      A_SR:    rdata = sr_q;
      A_MODE:  rdata = mode_q;
      A_FLG:   rdata = {irq, t1_flag, 3'b000, sr_flag, 2'b00};
      A_ENA:   rdata = {1'b0, t1_ena, 3'b000, sr_ena, 2'b00};
      default: rdata = 8'h00;
    endcase
  end

  assert_merge_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_T1L) |=> (t1_cnt == {$past(t1_cnt[15:8]), $past(wdata)}));

  assert_latch_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_LL || addr == A_LH) && !tick) |=> $stable(t1_cnt));

  assert_no_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_t2) |=> $stable(t2_cnt));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_cont && tick && !wr_t1 && t1_cnt == 16'd0) |=> (t1_cnt == $past(t1_latch) - 16'd1));

  assert_flag_only_cont_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t1_flag) |-> $past(mode_q[7:6] == MODE_CONT && tick && t1_cnt == 16'd0));

  assert_flag_write_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FLG && wdata[6] && !t1_fire) |=> !t1_flag);

  assert_sr_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_SR && !shift_done) |=> !sr_flag);
endmodule

// File: tb/ivt_timer_tb.sv
module ivt_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, shift_done = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  int checks = 0, fails = 0, cyc = 0;

  ivt_timer u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .tick(tick), .shift_done(shift_done), .irq(irq));

  always #10 clk = ~clk;

  // {counter, latch, tick gap}
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {16'd5,   16'd3,   8'd1},
    {16'd0,   16'd1,   8'd1},
    {16'd10,  16'd7,   8'd3},
    {16'd300, 16'd25,  8'd2},
    {16'd1,   16'h0100,8'd1},
    {16'd0,   16'd2,   8'd4}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic run_irq(input int gap, input int limit, output int n);
    n = 0;
    for (int c = 0; c < limit * gap + 4; c++) begin
      if (irq) break;
      tick = (c % gap == 0);
      if (tick) n++;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  logic [7:0] d, d2;
  int n;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(4'd4, d); rd(4'd5, d2); check("R1 t1 count", {d2, d}, 16'hFFFF);
    rd(4'd8, d); rd(4'd9, d2); check("R1 t2 count", {d2, d}, 16'hFFFF);
    rd(4'd6, d); rd(4'd7, d2); check("R1 latch", {d2, d}, 0);
    rd(4'd13, d); check("R1 flags", d, 0);
    rd(4'd14, d); check("R1 enables", d, 0);
    check("R1 irq", irq, 0);

    // reset count 0xFFFF expires after 65536 ticks
    wr(4'd14, 8'hC4);
    rd(4'd14, d); check("R9 enable set", d, 8'h44);
    wr(4'd11, 8'h40);
    run_irq(1, 70000, n); check("R5 reset count expiry", n, 65536);
    wr(4'd13, 8'h40); check("R9 flag clear irq", irq, 0);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] c, l;
      int g;
      c = VEC[v][39:24]; l = VEC[v][23:8]; g = int'(VEC[v][7:0]);
      wr(4'd6, l[7:0]); wr(4'd7, l[15:8]);
      wr(4'd4, c[7:0]); wr(4'd5, c[15:8]);
      wr(4'd13, 8'h44);
      run_irq(g, 70000, n); check($sformatf("R5 vec%0d first", v), n, c + 1);
      wr(4'd13, 8'h40);
      run_irq(g, 70000, n); check($sformatf("R5 vec%0d period", v), n, (l == 0) ? 65536 : l);
      wr(4'd13, 8'h40);
    end

    // merge and live reads, mode off
    wr(4'd11, 8'h00);
    wr(4'd4, 8'hFF); wr(4'd5, 8'hFF);
    wr(4'd4, 8'h12);
    rd(4'd4, d); rd(4'd5, d2); check("R2 low merge", {d2, d}, 16'hFF12);
    wr(4'd5, 8'h34);
    rd(4'd4, d); rd(4'd5, d2); check("R2 high merge", {d2, d}, 16'h3412);
    repeat (5) @(negedge clk);
    rd(4'd4, d); check("R4 no tick hold", d, 8'h12);
    ticks(3);
    rd(4'd4, d); check("R4 three ticks", d, 8'h0F);
    wr(4'd6, 8'hAB); wr(4'd7, 8'hCD);
    rd(4'd4, d); rd(4'd5, d2); check("R3 counter kept", {d2, d}, 16'h340F);
    rd(4'd6, d); rd(4'd7, d2); check("R3 latch read", {d2, d}, 16'hCDAB);
    // write with tick in same cycle: write wins
    tick = 1'b1; wr(4'd4, 8'h50); tick = 1'b0;
    rd(4'd4, d); check("R2 write beats tick", d, 8'h50);

    // non-continuous wrap, no flag
    wr(4'd4, 8'h02); wr(4'd5, 8'h00);
    ticks(10);
    rd(4'd4, d); rd(4'd5, d2); check("R6 wrap value", {d2, d}, 16'hFFF8);
    rd(4'd13, d); check("R6 no flag", d, 0);
    wr(4'd11, 8'hC0);
    wr(4'd4, 8'h01); wr(4'd5, 8'h00);
    ticks(6);
    rd(4'd13, d); check("R6 mode 11 no flag", d, 0);
    wr(4'd11, 8'h40);
    wr(4'd4, 8'h14); wr(4'd5, 8'h00);
    ticks(5);
    wr(4'd11, 8'h00);
    ticks(40);
    rd(4'd13, d); check("R6 disarm", {7'd0, irq} | d, 0);

    // timer 2
    wr(4'd8, 8'h03); wr(4'd9, 8'h00);
    rd(4'd8, d); rd(4'd9, d2); check("R7 t2 load", {d2, d}, 16'h0003);
    ticks(6);
    rd(4'd8, d); rd(4'd9, d2); check("R7 t2 wrap", {d2, d}, 16'hFFFD);
    wr(4'd9, 8'h77);
    rd(4'd8, d); rd(4'd9, d2); check("R7 t2 high merge", {d2, d}, 16'h77FD);
    rd(4'd13, d); check("R7 no flag", d, 0);

    // shift register flag
    wr(4'd10, 8'h5A);
    shift_done = 1'b1; @(negedge clk); shift_done = 1'b0;
    rd(4'd13, d); check("R10 shift flag set", d, 8'h84);
    check("R8 irq shift", irq, 1);
    rd(4'd10, d); check("R10 sr value", d, 8'h5A);
    rd(4'd13, d); check("R10 read clears", d, 0);

    // T1 flag via one expiry
    wr(4'd11, 8'h40);
    wr(4'd4, 8'h00); wr(4'd5, 8'h00);
    ticks(1);
    wr(4'd11, 8'h00);
    check("R8 irq t1", irq, 1);
    wr(4'd14, 8'h40);
    rd(4'd13, d); check("R9 masked flag kept", d, 8'h40);
    check("R8 masked irq", irq, 0);
    wr(4'd14, 8'hC0);
    check("R9 re-enable irq", irq, 1);
    rd(4'd4, d);
    rd(4'd13, d); check("R11 read clears t1", d, 0);

    // set beats clear: expiry in the cycle of a flag-clear write
    wr(4'd11, 8'h40);
    wr(4'd4, 8'h00); wr(4'd5, 8'h00);
    addr = 4'd13; wdata = 8'h40; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    wr(4'd11, 8'h00);
    rd(4'd13, d); check("R11 set wins", d, 8'hC0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule